// File: doc/BRIEF.md
# Batch-Mean Median-of-Three Noise Estimator

This block tracks the background noise of a stream of signed samples and turns it into a detection threshold. Each accepted sample is reduced to its magnitude and summed over a batch of 64 consecutive accepted samples. The batch mean is taken by dropping the six low bits of the sum. The three most recent batch means feed a median selector built from three pairwise comparisons and a multiplexer. The median becomes the noise level. The noise level multiplied by a constant sensitivity factor (17 by default) becomes the threshold. Both are registered and held between batch completions.

A spike comparator downstream compares an energy signal against `threshold` once `threshold_valid` is high. A small state machine sequences the warm-up and steady operation. It starts in WARM0 and steps WARM0 -> WARM1 -> WARM2 -> LIVE, taking one step on each batch completion. LIVE is the steady state and loops to itself on every further completion. On each accepted sample the machine issues an accumulate control. On the 64th sample of a batch it issues a clear control, and in WARM2 and LIVE it also issues an update control. The clear control also shifts the mean history.

Top module: `noise_thresh_est`

## Requirements
- R1: The magnitude of a sample is its absolute value on 9 bits, and the most negative input (-512) saturates to 511.
- R2: A batch is exactly 64 cycles with `sample_valid` high, and cycles with `sample_valid` low contribute nothing. The batch mean is the floor of the sum of the 64 magnitudes divided by 64, and the next batch starts on the very next accepted sample.
- R3: The batch sum never overflows. A batch of 64 samples of magnitude 511 gives a mean of 511.
- R4: On each update, `noise_level` becomes the median of the newest batch mean and the two means before it.
- R5: `threshold` always equals `noise_level` times 17.
- R6: After reset, `noise_level`, `threshold` and `threshold_valid` are all 0.
- R7: `threshold_valid` rises, and `noise_level` and `threshold` first change, in the cycle after the third batch completes. Before that they stay 0, and once high `threshold_valid` stays high.
- R8: The outputs change only in the cycle after a batch completes and hold their values at all other times, including mid-batch.
- R9: The state sequence is WARM0 -> WARM1 -> WARM2 -> LIVE, one step per batch completion. LIVE is held, and `threshold_valid` is high exactly in LIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Sample qualifier; high accepts `sample_in` this cycle |
| sample_in | input | 10 | Signed two's-complement sample |
| noise_level | output | 9 | Median of the last three batch means |
| threshold | output | 14 | Noise level times the sensitivity factor |
| threshold_valid | output | 1 | High once three batches have completed |

## Verification
A miscounted batch counter or a lost sample shows up as a wrong `noise_level` exactly one cycle after the expected 64th accepted sample. It can also show up as an output that changes at the wrong time, which the mid-batch hold checks catch. A wrong history shift or median selection appears at the first update whose three means are distinct and ordered differently from the previous ones, so directed ascending, descending and tied orderings expose it within three batches. A stuck state machine shows as `threshold_valid` rising one batch early or late.

// File: rtl/nte_pkg.sv
package nte_pkg;
    typedef enum logic [1:0] {
        ST_WARM0 = 2'd0,
        ST_WARM1 = 2'd1,
        ST_WARM2 = 2'd2,
        ST_LIVE  = 2'd3
    } est_state_t;
endpackage

// File: rtl/nte_magnitude.sv
module nte_magnitude #(
    parameter int SAMPLE_W = 10
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic        [SAMPLE_W-2:0] mag_o
);
    logic [SAMPLE_W-1:0] neg_w;

    assign neg_w = -sample_i;

    always_comb begin
        if (!sample_i[SAMPLE_W-1]) begin
            mag_o = sample_i[SAMPLE_W-2:0];
        end else if (sample_i[SAMPLE_W-2:0] == '0) begin
            mag_o = '1;   // most negative value saturates (R1)
        end else begin
            mag_o = neg_w[SAMPLE_W-2:0];
        end
    end
endmodule

// File: rtl/nte_batch_acc.sv
module nte_batch_acc #(
    parameter int MAG_W      = 9,
    parameter int BATCH_LOG2 = 6,
    localparam int ACC_W     = MAG_W + BATCH_LOG2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accum_i,
    input  logic                  clear_i,
    input  logic [MAG_W-1:0]      mag_i,
    output logic                  last_o,
    output logic [MAG_W-1:0]      mean_o,
    output logic [ACC_W-1:0]      acc_o,
    output logic [BATCH_LOG2-1:0] cnt_o
);
    logic [ACC_W-1:0]      acc_q;
    logic [BATCH_LOG2-1:0] cnt_q;
    logic [ACC_W-1:0]      sum_w;

    assign sum_w  = acc_q + ACC_W'(mag_i);
    assign mean_o = sum_w[ACC_W-1:BATCH_LOG2];
    assign last_o = (cnt_q == '1);
    assign acc_o  = acc_q;
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (accum_i) begin
            acc_q <= sum_w;
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/nte_median3.sv
module nte_median3 #(
    parameter int VAL_W = 9
) (
    input  logic [VAL_W-1:0] a_i,   // newest
    input  logic [VAL_W-1:0] b_i,
    input  logic [VAL_W-1:0] c_i,   // oldest
    output logic [VAL_W-1:0] med_o
);
    logic gt_ab, gt_bc, gt_ac;

    assign gt_ab = (a_i > b_i);
    assign gt_bc = (b_i > c_i);
    assign gt_ac = (a_i > c_i);

    always_comb begin
        unique case ({gt_ab, gt_bc})
            2'b00, 2'b11: med_o = b_i;
            2'b10:        med_o = gt_ac ? c_i : a_i;
            2'b01:        med_o = gt_ac ? a_i : c_i;
            default:      med_o = b_i;
        endcase
    end
endmodule

// File: rtl/noise_thresh_est.sv
module noise_thresh_est #(
    parameter int SAMPLE_W   = 10,
    parameter int BATCH_LOG2 = 6,
    parameter int SCALE      = 17,
    localparam int MAG_W     = SAMPLE_W - 1,
    localparam int ACC_W     = MAG_W + BATCH_LOG2,
    localparam int SCALE_W   = $clog2(SCALE + 1),
    localparam int THR_W     = MAG_W + SCALE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic        [MAG_W-1:0]    noise_level,
    output logic        [THR_W-1:0]    threshold,
    output logic                       threshold_valid
);
    import nte_pkg::*;

    localparam int HIST_N = 2;
    localparam logic [THR_W-1:0] SCALE_C = THR_W'(SCALE);

    est_state_t state_q, state_d;

    logic                  ctl_accum, ctl_clear, ctl_update;
    logic [MAG_W-1:0]      mag_w, mean_w, med_w;
    logic                  last_w;
    logic [ACC_W-1:0]      acc_w;
    logic [BATCH_LOG2-1:0] cnt_w;
    logic [MAG_W-1:0]      hist_q [HIST_N];
    logic [THR_W-1:0]      prod_w;

    nte_magnitude #(.SAMPLE_W(SAMPLE_W)) mag_i (
        .sample_i (sample_in),
        .mag_o    (mag_w)
    );

    nte_batch_acc #(.MAG_W(MAG_W), .BATCH_LOG2(BATCH_LOG2)) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .accum_i (ctl_accum),
        .clear_i (ctl_clear),
        .mag_i   (mag_w),
        .last_o  (last_w),
        .mean_o  (mean_w),
        .acc_o   (acc_w),
        .cnt_o   (cnt_w)
    );

    nte_median3 #(.VAL_W(MAG_W)) med_i (
        .a_i   (mean_w),
        .b_i   (hist_q[0]),
        .c_i   (hist_q[1]),
        .med_o (med_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WARM0;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM0: if (ctl_clear) state_d = ST_WARM1;
            ST_WARM1: if (ctl_clear) state_d = ST_WARM2;
            ST_WARM2: if (ctl_clear) state_d = ST_LIVE;
            ST_LIVE:  state_d = ST_LIVE;
            default:  state_d = ST_WARM0;
        endcase
    end

    // Control outputs
    always_comb begin
        ctl_accum  = sample_valid;
        ctl_clear  = sample_valid && last_w;
        ctl_update = 1'b0;
        unique case (state_q)
            ST_WARM0, ST_WARM1: ctl_update = 1'b0;
            ST_WARM2, ST_LIVE:  ctl_update = ctl_clear;
            default:            ctl_update = 1'b0;
        endcase
    end

    // Mean history shift
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST_N; i++) hist_q[i] <= '0;
        end else if (ctl_clear) begin
            hist_q[0] <= mean_w;
            for (int i = 1; i < HIST_N; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    assign prod_w = THR_W'(med_w) * SCALE_C;

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            noise_level     <= '0;
            threshold       <= '0;
            threshold_valid <= 1'b0;
        end else if (ctl_update) begin
            noise_level     <= med_w;
            threshold       <= prod_w;
            threshold_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/nte_checker.sv
module nte_checker #(
    parameter int SAMPLE_W   = 10,
    parameter int BATCH_LOG2 = 6,
    parameter int SCALE      = 17,
    localparam int MAG_W     = SAMPLE_W - 1,
    localparam int ACC_W     = MAG_W + BATCH_LOG2,
    localparam int SCALE_W   = $clog2(SCALE + 1),
    localparam int THR_W     = MAG_W + SCALE_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_valid,
    input logic [MAG_W-1:0]        noise_level,
    input logic [THR_W-1:0]        threshold,
    input logic                    threshold_valid,
    input nte_pkg::est_state_t     state_q,
    input logic [ACC_W-1:0]        acc_w,
    input logic [BATCH_LOG2-1:0]   cnt_w
);
    localparam logic [ACC_W-1:0] MAX_MAG = ACC_W'((1 << MAG_W) - 1);

    // R3: partial sum bounded by sample count times largest magnitude
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        acc_w <= ACC_W'(cnt_w) * MAX_MAG);

    // R5: threshold tracks scaled noise level
    a_r5_scaled: assert property (@(posedge clk) disable iff (!rst_n)
        threshold == THR_W'(noise_level) * THR_W'(SCALE));

    // R6/R7: outputs zero while not valid
    a_r7_zero_before_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !threshold_valid |-> (threshold == '0 && noise_level == '0));

    // R7: valid is sticky
    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        threshold_valid |=> threshold_valid);

    // R8: no accepted sample, no output change
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(threshold) && $stable(noise_level)));

    // R9: valid exactly in LIVE, LIVE held
    a_r9_valid_in_live: assert property (@(posedge clk) disable iff (!rst_n)
        threshold_valid == (state_q == nte_pkg::ST_LIVE));

    a_r9_live_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == nte_pkg::ST_LIVE) |=> (state_q == nte_pkg::ST_LIVE));
endmodule

bind noise_thresh_est nte_checker #(
    .SAMPLE_W   (SAMPLE_W),
    .BATCH_LOG2 (BATCH_LOG2),
    .SCALE      (SCALE)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_valid    (sample_valid),
    .noise_level     (noise_level),
    .threshold       (threshold),
    .threshold_valid (threshold_valid),
    .state_q         (state_q),
    .acc_w           (acc_w),
    .cnt_w           (cnt_w)
);

// File: tb/noise_thresh_est_tb.sv
module noise_thresh_est_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_valid = 1'b0;
    logic signed [9:0] sample_in = '0;
    logic [8:0]        noise_level;
    logic [13:0]       threshold;
    logic              threshold_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    int h0 = 0, h1 = 0, h2 = 0;   // newest .. oldest batch mean
    int batches = 0;
    int exp_noise = 0;

    always #2.5 clk = ~clk;

    noise_thresh_est dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .sample_valid    (sample_valid),
        .sample_in       (sample_in),
        .noise_level     (noise_level),
        .threshold       (threshold),
        .threshold_valid (threshold_valid)
    );

    function automatic int mag_of(input int v);
        if (v == -512) return 511;
        return (v < 0) ? -v : v;
    endfunction

    function automatic int med3(input int a, input int b, input int c);
        int mx, mn;
        mx = (a > b) ? a : b; mx = (mx > c) ? mx : c;
        mn = (a < b) ? a : b; mn = (mn < c) ? mn : c;
        return a + b + c - mx - mn;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " noise_level"}, int'(noise_level), exp_noise);
        check({req, " threshold"}, int'(threshold), exp_noise * 17);
        check({req, " valid"}, int'(threshold_valid), (batches >= 3) ? 1 : 0);
    endtask

    // mode 0: constant value cval; mode 1: random; random idle gaps with garbage data
    task automatic run_batch(input int mode, input int cval, input string req);
        int sum = 0;
        for (int i = 0; i < 64; i++) begin
            int v;
            while ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                sample_valid = 1'b0;
                sample_in = 10'($urandom_range(0, 1023));   // R2: ignored
            end
            v = (mode == 0) ? cval : int'($signed(10'($urandom_range(0, 1023))));
            if (mode == 1 && $urandom_range(0, 15) == 0) v = -512;
            @(negedge clk);
            sample_valid = 1'b1;
            sample_in = 10'(v);
            sum += mag_of(v);
            if (i == 32) begin
                // mid-batch: outputs still hold previous values (R8)
                check_outputs("R8 mid-batch hold");
            end
        end
        @(negedge clk);
        sample_valid = 1'b0;
        h2 = h1; h1 = h0; h0 = sum / 64;
        batches++;
        if (batches >= 3) exp_noise = med3(h0, h1, h2);
        check_outputs(req);
        @(negedge clk);
        check_outputs("R8 hold after update");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_outputs("R6 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R6 after reset release");

        // Warm-up: valid stays low until third batch (R7, R9)
        run_batch(0, 100, "R7 R9 batch1 no update");
        run_batch(0, -512, "R1 R3 R7 batch2 saturated no update");
        run_batch(0, -37, "R1 R4 R7 R9 batch3 first update");
        // history 37, 511, 100 -> median 100
        check("R4 first median", int'(noise_level), 100);

        // Directed orderings (R4)
        run_batch(0, 10, "R4 batch");
        run_batch(0, 20, "R4 batch");
        run_batch(0, 30, "R4 ascending");
        run_batch(0, -20, "R4 descending-tie");
        run_batch(0, 5, "R4 descending");
        run_batch(0, 5, "R4 tie newest pair");
        run_batch(0, 9, "R4 tie older pair");
        run_batch(0, 511, "R3 R5 maximum");
        run_batch(0, 0, "R4 zero");

        // Random batches with gaps (R1, R2, R4, R5)
        for (int k = 0; k < 12; k++) run_batch(1, 0, "R2 R4 R5 random batch");

        // Long idle: nothing changes (R2, R8)
        repeat (50) begin
            @(negedge clk);
            sample_valid = 1'b0;
            sample_in = 10'($urandom_range(0, 1023));
        end
        check_outputs("R2 idle no effect");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule